// File: doc/BRIEF.md
# Self-Routing Cell Crossbar, Four Ports

The block is a cell-synchronous crossbar with four byte-wide inputs and four byte-wide outputs. Each cell opens with a header byte that names its destination output and carries a one-bit priority. The payload bytes follow the header back to back. An external frame pulse marks the start of each cell period. The block waits for the first active header after that pulse and arbitrates once. It then steers each winning payload to its output and removes the header on the way.

When several cells ask for the same output, only priority cells stay in contention if any of them is present. The winner is then chosen by a round-robin pointer that each output keeps for itself. An acknowledgement returns from every output to the input that won it. This path is combinational and does not pass through a register. Inputs that lost, or that sent no cell, see their acknowledgement held low. Each selection stays in force until the next frame pulse.

Top module: `cellCrossbar`

## Requirements
- R1: After reset every output byte is zero and every acknowledgement to the inputs is low, whatever the output side returns.
- R2: In the header byte, bit 7 marks the cell as active, bit 6 sets its priority and bits 1:0 give the destination output. Bits 5:2 have no effect on routing. A header with bit 7 clear requests nothing.
- R3: The header byte never appears at an output. An output carries zero in the cycle where the header would fall. The first payload byte of a winning cell appears at its output 5 clocks after its header was presented at the input, and each later byte follows one clock after the one before.
- R4: If a priority cell and non-priority cells request the same output, a priority cell wins that output, whatever the round-robin pointer holds.
- R5: Among the cells still contending for an output, the winner is the first requesting input above the last input granted that output, counting upward with wrap-around from 3 to 0. The pointer starts at 3 after reset, and every grant of either priority moves it.
- R6: An input that won an output sees that output's acknowledgement within the same cycle. Every other input sees a low acknowledgement.
- R7: An output that no input won carries zero data.
- R8: Arbitration happens only after a frame pulse, and only once for each pulse. Active headers that arrive with no frame pulse before them route nothing.
- R9: Grants and acknowledgement routes stay fixed from arbitration until the next frame pulse. That pulse releases them, after which the outputs go to zero and the acknowledgements go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse that opens a cell period |
| inData | input | 4x8 | Input bytes, one byte per port |
| ackFromOut | input | 4 | Acknowledgement returned by each output-side controller |
| outData | output | 4x8 | Output bytes, one byte per port |
| ackToIn | output | 4 | Acknowledgement delivered to each input |

## Verification
Two functions act on the same arbitration pulse: the priority filter and the round-robin choice. The bench provokes this by sending a priority cell to an output together with non-priority cells, at a moment when the pointer would favour a non-priority input. It then checks that the priority input's payload alone reaches that output and that only the priority input is acknowledged. Contention scenarios that repeat back to back check that the pointer moves after every grant. The acknowledgement return is read in the same frames as the payload, under two different output-side patterns, so the bench sees both the forwarded values and the forced lows.

// File: rtl/fabricPkg.sv
package fabricPkg;
  localparam int PORTS    = 4;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = $clog2(PORTS);
  localparam int ACT_BIT  = DATA_W - 1;
  localparam int PRIO_BIT = DATA_W - 2;

  typedef enum logic [1:0] {ST_RUN, ST_WAIT, ST_ROUTE} phaseT;

  typedef struct packed {
    logic             act;
    logic             pri;
    logic [SEL_W-1:0] dst;
  } headT;

  typedef struct packed {
    logic [PORTS-1:0][SEL_W-1:0] sel;
    logic [PORTS-1:0]            grantVld;
    logic                        dataEn;
  } strobeT;
endpackage

// File: rtl/rrArbiter.sv
module rrArbiter
  import fabricPkg::*;
#(
  parameter int N = PORTS,
  localparam int SW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fire,
  input  logic          clear,
  input  logic [N-1:0]  req,
  output logic          grantVld,
  output logic [SW-1:0] sel
);
  logic [SW-1:0] lastGrant;
  logic [SW-1:0] pick;
  logic          found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      logic [SW-1:0] idx;
      idx = lastGrant + SW'(k);
      if (!found && req[idx]) begin
        pick  = idx;
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastGrant <= SW'(N - 1);
      grantVld  <= 1'b0;
      sel       <= '0;
    end else if (fire) begin
      grantVld <= found;
      if (found) begin
        sel       <= pick;
        lastGrant <= pick;
      end
    end else if (clear) begin
      grantVld <= 1'b0;
    end
  end

  // R5: a pulse with requests always yields a grant
  p_grant_on_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (req != '0)) |=> grantVld);
  // R5: a pulse without requests yields none
  p_no_grant_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (fire && (req == '0)) |=> !grantVld);
endmodule

// File: rtl/fabricCtrl.sv
module fabricCtrl
  import fabricPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  frameStart,
  input  headT [PORTS-1:0]      heads,
  output strobeT                strobes
);
  phaseT phase, phaseNext;
  logic  anyActive;
  logic  routeD1;
  logic  dataEn;
  logic [PORTS-1:0][PORTS-1:0] reqRaw, reqPri, reqFilt, reqReg;
  logic [PORTS-1:0][SEL_W-1:0] selArr;
  logic [PORTS-1:0]            grantArr;

  always_comb begin
    anyActive = 1'b0;
    for (int i = 0; i < PORTS; i++) anyActive = anyActive | heads[i].act;
  end

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      ST_RUN:   if (frameStart) phaseNext = ST_WAIT;
      ST_WAIT:  if (anyActive)  phaseNext = ST_ROUTE;
      ST_ROUTE: phaseNext = ST_RUN;
      default:  phaseNext = ST_RUN;
    endcase
  end

  // decode and priority filter, one row per output
  always_comb begin
    for (int o = 0; o < PORTS; o++) begin
      for (int i = 0; i < PORTS; i++) begin
        reqRaw[o][i] = heads[i].act && (heads[i].dst == SEL_W'(o));
        reqPri[o][i] = reqRaw[o][i] && heads[i].pri;
      end
      reqFilt[o] = (reqPri[o] != '0) ? reqPri[o] : reqRaw[o];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_RUN;
      reqReg  <= '0;
      routeD1 <= 1'b0;
      dataEn  <= 1'b0;
    end else begin
      phase   <= phaseNext;
      reqReg  <= reqFilt;
      routeD1 <= (phase == ST_ROUTE);
      if (routeD1)         dataEn <= 1'b1;
      else if (frameStart) dataEn <= 1'b0;
    end
  end

  for (genvar o = 0; o < PORTS; o++) begin : g_arb
    rrArbiter #(.N(PORTS)) i_rrArbiter (
      .clk      (clk),
      .rstN     (rstN),
      .fire     (phase == ST_ROUTE),
      .clear    (frameStart),
      .req      (reqReg[o]),
      .grantVld (grantArr[o]),
      .sel      (selArr[o])
    );
  end

  always_comb begin
    strobes.sel      = selArr;
    strobes.grantVld = grantArr;
    strobes.dataEn   = dataEn;
  end

  // R8: the route phase lasts a single cycle
  p_route_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_ROUTE) |=> (phase == ST_RUN));
  // R8: without a frame pulse the controller stays idle
  p_no_spurious_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phase == ST_RUN && !frameStart) |=> (phase == ST_RUN));
  // R3: output enable opens two cycles after the route phase
  p_enable_after_route_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataEn) |-> $past(phase == ST_ROUTE, 2));

  // R5: an input never holds more than one output
  for (genvar i = 0; i < PORTS; i++) begin : g_oneWin
    logic [PORTS-1:0] winMap;
    always_comb
      for (int o = 0; o < PORTS; o++)
        winMap[o] = grantArr[o] && (selArr[o] == SEL_W'(i));
    p_single_output_r5: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(winMap));
  end
endmodule

// File: rtl/fabricPath.sv
module fabricPath
  import fabricPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PORTS-1:0][DATA_W-1:0]  inData,
  input  logic [PORTS-1:0]              ackFromOut,
  input  strobeT                        strobes,
  output headT [PORTS-1:0]              heads,
  output logic [PORTS-1:0][DATA_W-1:0]  outData,
  output logic [PORTS-1:0]              ackToIn
);
  logic [PORTS-1:0][DATA_W-1:0] inReg, dly1, dly2, muxOut;

  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      heads[i].act = inReg[i][ACT_BIT];
      heads[i].pri = inReg[i][PRIO_BIT];
      heads[i].dst = inReg[i][SEL_W-1:0];
    end
  end

  always_comb begin
    for (int o = 0; o < PORTS; o++)
      muxOut[o] = (strobes.dataEn && strobes.grantVld[o]) ? dly2[strobes.sel[o]] : '0;
  end

  always_comb begin
    for (int i = 0; i < PORTS; i++) begin
      ackToIn[i] = 1'b0;
      for (int o = 0; o < PORTS; o++)
        if (strobes.grantVld[o] && strobes.sel[o] == SEL_W'(i))
          ackToIn[i] = ackToIn[i] | ackFromOut[o];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inReg   <= '0;
      dly1    <= '0;
      dly2    <= '0;
      outData <= '0;
    end else begin
      inReg   <= inData;
      dly1    <= inReg;
      dly2    <= dly1;
      outData <= muxOut;
    end
  end

  // R6: an acknowledgement only flows over a granted route
  p_ack_needs_grant_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ackToIn != '0) |-> (strobes.grantVld != '0));
  // R9: selections do not move while data is flowing
  p_sel_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataEn && $past(strobes.dataEn)) |-> $stable(strobes.sel));
  // R7: with the path closed the outputs are quiet next cycle
  p_out_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.dataEn |=> (outData == '0));
endmodule

// File: rtl/cellCrossbar.sv
module cellCrossbar
  import fabricPkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          frameStart,
  input  logic [PORTS-1:0][DATA_W-1:0]  inData,
  input  logic [PORTS-1:0]              ackFromOut,
  output logic [PORTS-1:0][DATA_W-1:0]  outData,
  output logic [PORTS-1:0]              ackToIn
);
  strobeT           strobes;
  headT [PORTS-1:0] heads;

  fabricCtrl i_fabricCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameStart (frameStart),
    .heads      (heads),
    .strobes    (strobes)
  );

  fabricPath i_fabricPath (
    .clk        (clk),
    .rstN       (rstN),
    .inData     (inData),
    .ackFromOut (ackFromOut),
    .strobes    (strobes),
    .heads      (heads),
    .outData    (outData),
    .ackToIn    (ackToIn)
  );
endmodule

// File: tb/test_cellCrossbar.sv
module test_cellCrossbar;
  localparam int L = 6;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            frameStart = 1'b0;
  logic [3:0][7:0] inData = '0;
  logic [3:0]      ackFromOut = '0;
  logic [3:0][7:0] outData;
  logic [3:0]      ackToIn;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;
  int lastG [4] = '{3, 3, 3, 3};

  always #10 clk = ~clk;

  cellCrossbar i_cellCrossbar (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .inData(inData),
    .ackFromOut(ackFromOut), .outData(outData), .ackToIn(ackToIn)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] payload(int i, int k);
    return 8'((i << 4) | k);
  endfunction

  // drives one cell period and checks outputs and acknowledgements
  task automatic runCell(input logic [3:0] act, input logic [3:0] pri,
                         input int dst [4], input logic [3:0] junk,
                         input bit withFrame, input string req);
    int win [4];
    logic [3:0] ackA;
    logic [3:0] ackB;
    ackA = 4'b0101;
    ackB = 4'b1010;
    for (int o = 0; o < 4; o++) begin
      logic [3:0] cand;
      win[o] = -1;
      cand = '0;
      if (withFrame)
        for (int i = 0; i < 4; i++) cand[i] = act[i] && (dst[i] == o);
      if ((cand & pri) != 0) cand = cand & pri;
      for (int k = 1; k <= 4; k++) begin
        int idx;
        idx = (lastG[o] + k) % 4;
        if (win[o] < 0 && cand[idx]) win[o] = idx;
      end
      if (win[o] >= 0) lastG[o] = win[o];
    end
    @(negedge clk);
    frameStart = withFrame;
    inData = '0;
    @(negedge clk);
    frameStart = 1'b0;
    for (int i = 0; i < 4; i++)
      inData[i] = {act[i], pri[i], junk, 2'(dst[i])};
    for (int n = 1; n <= L + 5; n++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) inData[i] = (n <= L) ? payload(i, n) : 8'h00;
      if (n == 3) ackFromOut = ackA;
      if (n == 4) ackFromOut = ackB;
      if (n == L + 5) ackFromOut = 4'b1111;
      #1;
      if (n == 3 || n == 4 || n == L + 5)
        for (int i = 0; i < 4; i++) begin
          logic e;
          e = 1'b0;
          for (int o = 0; o < 4; o++) if (win[o] == i) e = ackFromOut[o];
          check((n == L + 5) ? "R9 held R6" : "R6", $sformatf("ack in%0d n%0d", i, n),
                32'(ackToIn[i]), 32'(e));
        end
      if (n == 4)
        for (int o = 0; o < 4; o++)
          check("R3 strip", $sformatf("out%0d header slot", o), 32'(outData[o]), 32'h0);
      if (n >= 5 && n - 4 <= L)
        for (int o = 0; o < 4; o++)
          check((win[o] >= 0) ? {req, "/R3"} : "R7",
                $sformatf("out%0d byte%0d", o, n - 4), 32'(outData[o]),
                (win[o] >= 0) ? 32'(payload(win[o], n - 4)) : 32'h0);
    end
    @(negedge clk);
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    @(negedge clk);
    #1;
    check("R9 release", "acks after frame pulse", 32'(ackToIn), 32'h0);
    check("R9 release", "outputs after frame pulse", 32'(outData), 32'h0);
  endtask

  task automatic t_reset;
    ackFromOut = 4'b1111;
    #1;
    check("R1", "outputs after reset", 32'(outData), 32'h0);
    check("R1", "acks after reset", 32'(ackToIn), 32'h0);
  endtask

  task automatic t_noFrame;
    int d [4] = '{0, 1, 2, 3};
    runCell(4'b1111, 4'b0000, d, 4'b0000, 1'b0, "R8");
  endtask

  task automatic t_permutation;
    int d [4] = '{2, 0, 3, 1};
    runCell(4'b1111, 4'b0000, d, 4'b1010, 1'b1, "R2");
  endtask

  task automatic t_contend;
    int d [4] = '{1, 1, 1, 1};
    runCell(4'b1111, 4'b0000, d, 4'b0000, 1'b1, "R5");
    runCell(4'b1111, 4'b0000, d, 4'b0110, 1'b1, "R5");
  endtask

  task automatic t_priority;
    int d [4] = '{2, 2, 2, 2};
    runCell(4'b1101, 4'b1010, d, 4'b0000, 1'b1, "R4");
  endtask

  task automatic t_sparse;
    int d [4] = '{1, 3, 0, 2};
    runCell(4'b0100, 4'b0011, d, 4'b1111, 1'b1, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_noFrame();
    t_permutation();
    t_contend();
    t_priority();
    t_sparse();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule